// File: doc/BRIEF.md
# Packet Burst Boundary Detector

This block takes one record per received frame: the frame length in bytes and its arrival time, counted in byte-times. For each frame after the first, it works out the idle time since the end of the previous frame as the timestamp difference minus the previous frame's length. A gap no larger than the programmed limit means the frame joins the open burst. A larger gap closes the open burst, and the new frame starts a fresh one. Each closed burst leaves the block as one record carrying its frame count and its byte count.

The gap limit is programmed without the 8 bytes of preamble and start delimiter, while the measured gap includes them. The block adds those 8 bytes to the limit internally before the comparison. Both streams use valid/ready handshakes. A frame is taken on a cycle where `in_valid` and `in_ready` are both high. A burst record is taken on a cycle where `out_valid` and `out_ready` are both high. Record storage is a single slot. While that slot holds a record that is not being taken, `in_ready` stays low, so back-pressure on the output reaches the input directly. `enable` and `flush` are plain level controls.

Top module: `burst_gap_tracker`

## Requirements
- R1: For frames A then B, the gap is ts(B) − ts(A) − len(A). B extends the open burst when that gap is at most `gap_max` + 8, and closes it when the gap is one or more above that value.
- R2: When a burst closes, the output record carries the closed burst's frame count and byte total, and the closing frame becomes the single frame of a new burst.
- R3: The first frame accepted after reset, or after `enable` has been low, opens a burst and produces no output record.
- R4: A negative gap, which happens when B's timestamp falls inside A's length, counts as zero, so B extends the burst.
- R5: The effective limit `gap_max` + 8 saturates at 65535. With `gap_max` = 16'hFFFF, a gap of 65535 extends the burst and a gap of 65536 closes it.
- R6: While `flush` is high and `enable` is high, `in_ready` is low. A flush taken while a burst is open emits that burst and leaves no burst open. A flush taken with no burst open emits nothing.
- R7: The frame count saturates at its all-ones value (width PKT_W, default 32). The byte count saturates at its all-ones value (width BYTE_W, default 48).
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pkts` and `out_bytes` stay unchanged, and `in_ready` is low when `enable` is high.
- R9: While `enable` is low, `in_ready` is high. Frames offered in that state are consumed and discarded, and any open burst is dropped without an output record.
- R10: After reset, `out_valid` is low and no burst is open.
- R11: The timestamp difference is taken modulo 2^64, so a timestamp that wraps past zero still yields the correct gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Measurement on; when low, frames are discarded and the open burst is dropped |
| flush | input | 1 | Close and emit the open burst |
| gap_max | input | 16 | Largest in-burst gap, in bytes, excluding preamble and delimiter |
| in_valid | input | 1 | Frame record valid |
| in_ready | output | 1 | Frame record can be taken |
| in_ts | input | 64 | Frame arrival time in byte-times |
| in_len | input | 14 | Frame length in bytes |
| out_valid | output | 1 | Burst record valid |
| out_ready | input | 1 | Downstream takes the burst record |
| out_pkts | output | 32 | Frames in the closed burst |
| out_bytes | output | 48 | Bytes in the closed burst |

## Verification
The assertions check the output handshake on every cycle. A held record must keep its contents. A new record must never overwrite one that has not been taken. A stalled or flushing block must not accept input. An opening frame must not produce a record, and a saturated frame count must stay put. The arithmetic cannot be seen from one cycle alone: the gap boundary exactly at the limit, the clamped negative gap, the saturated limit, and the timestamp wrap. Dropping a burst when `enable` goes low also needs several cycles to show. The bench's directed scenarios cover all of these and compare each emitted record with a count worked out from the frames it sent.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
  localparam int unsigned FRAMING_BYTES = 8;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_OPEN,
    ACT_EXTEND,
    ACT_SPLIT
  } pkt_act_e;
endpackage

// File: rtl/bgt_gap_judge.sv
module bgt_gap_judge #(
  parameter int TS_W  = 64,
  parameter int LEN_W = 14,
  parameter int GAP_W = 16
) (
  input  logic [TS_W-1:0]  prev_ts,
  input  logic [LEN_W-1:0] prev_len,
  input  logic [TS_W-1:0]  cur_ts,
  input  logic [GAP_W-1:0] gap_max,
  output logic             extend
);
  import bgt_pkg::*;

  localparam int DIFF_W = TS_W + 1;
  localparam int LIM_W  = GAP_W + 1;

  logic [TS_W-1:0]   ts_delta;
  logic [DIFF_W-1:0] gap_full;
  logic [LIM_W-1:0]  lim_sum;
  logic [GAP_W-1:0]  limit;

  always_comb begin
    // modulo subtraction handles wrap of the time counter (R11)
    ts_delta = cur_ts - prev_ts;
    gap_full = {1'b0, ts_delta} - DIFF_W'(prev_len);
    // register excludes preamble/delimiter; add it back, saturating (R5)
    lim_sum  = LIM_W'(gap_max) + LIM_W'(FRAMING_BYTES);
    limit    = lim_sum[GAP_W] ? '1 : lim_sum[GAP_W-1:0];
    // negative gap (borrow) is treated as zero, i.e. continuation (R4)
    extend   = gap_full[TS_W] | (gap_full[TS_W-1:0] <= TS_W'(limit));
  end
endmodule

// File: rtl/bgt_accum.sv
module bgt_accum #(
  parameter int TS_W   = 64,
  parameter int LEN_W  = 14,
  parameter int GAP_W  = 16,
  parameter int PKT_W  = 32,
  parameter int BYTE_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              take,
  input  logic [TS_W-1:0]   cur_ts,
  input  logic [LEN_W-1:0]  cur_len,
  input  logic [GAP_W-1:0]  gap_max,
  input  logic              flush_take,
  output logic              emit,
  output logic [PKT_W-1:0]  emit_pkts,
  output logic [BYTE_W-1:0] emit_bytes
);
  import bgt_pkg::*;

  localparam int BSUM_W = BYTE_W + 1;

  logic              open_q;
  logic [PKT_W-1:0]  pkts_q;
  logic [BYTE_W-1:0] bytes_q;
  logic [TS_W-1:0]   prev_ts_q;
  logic [LEN_W-1:0]  prev_len_q;
  logic              extend;
  pkt_act_e          act;
  logic [PKT_W-1:0]  pkts_inc;
  logic [BSUM_W-1:0] bytes_sum;
  logic [BYTE_W-1:0] bytes_inc;

  bgt_gap_judge #(.TS_W(TS_W), .LEN_W(LEN_W), .GAP_W(GAP_W)) u_judge (
    .prev_ts (prev_ts_q),
    .prev_len(prev_len_q),
    .cur_ts  (cur_ts),
    .gap_max (gap_max),
    .extend  (extend)
  );

  always_comb begin
    if (!take)        act = ACT_IDLE;
    else if (!open_q) act = ACT_OPEN;
    else if (extend)  act = ACT_EXTEND;
    else              act = ACT_SPLIT;
    pkts_inc  = (pkts_q == '1) ? pkts_q : pkts_q + PKT_W'(1);
    bytes_sum = {1'b0, bytes_q} + BSUM_W'(cur_len);
    bytes_inc = bytes_sum[BYTE_W] ? '1 : bytes_sum[BYTE_W-1:0];
    emit      = enable & ((act == ACT_SPLIT) | (flush_take & open_q & ~take));
  end

  assign emit_pkts  = pkts_q;
  assign emit_bytes = bytes_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q     <= 1'b0;
      pkts_q     <= '0;
      bytes_q    <= '0;
      prev_ts_q  <= '0;
      prev_len_q <= '0;
    end else if (!enable) begin
      open_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_OPEN, ACT_SPLIT: begin
          open_q     <= 1'b1;
          pkts_q     <= PKT_W'(1);
          bytes_q    <= BYTE_W'(cur_len);
          prev_ts_q  <= cur_ts;
          prev_len_q <= cur_len;
        end
        ACT_EXTEND: begin
          pkts_q     <= pkts_inc;
          bytes_q    <= bytes_inc;
          prev_ts_q  <= cur_ts;
          prev_len_q <= cur_len;
        end
        default: begin
          if (flush_take) open_q <= 1'b0;
        end
      endcase
    end
  end

  assert_open_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !open_q) |-> !emit);
  assert_pkt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && open_q && extend && pkts_q == '1) |=> (pkts_q == '1));
  assert_emit_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (pkts_q != '0));
endmodule

// File: rtl/bgt_out_slot.sv
module bgt_out_slot #(
  parameter int PKT_W  = 32,
  parameter int BYTE_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PKT_W-1:0]  load_pkts,
  input  logic [BYTE_W-1:0] load_bytes,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [PKT_W-1:0]  out_pkts,
  output logic [BYTE_W-1:0] out_bytes,
  output logic              free
);
  assign free = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pkts  <= '0;
      out_bytes <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_pkts  <= load_pkts;
      out_bytes <= load_bytes;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pkts) && $stable(out_bytes)));
  assert_no_clobber_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));
endmodule

// File: rtl/burst_gap_tracker.sv
module burst_gap_tracker #(
  parameter int TS_W   = 64,
  parameter int LEN_W  = 14,
  parameter int GAP_W  = 16,
  parameter int PKT_W  = 32,
  parameter int BYTE_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              flush,
  input  logic [GAP_W-1:0]  gap_max,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PKT_W-1:0]  out_pkts,
  output logic [BYTE_W-1:0] out_bytes
);
  logic              slot_free;
  logic              take;
  logic              flush_take;
  logic              emit;
  logic [PKT_W-1:0]  emit_pkts;
  logic [BYTE_W-1:0] emit_bytes;

  assign in_ready   = ~enable | (slot_free & ~flush);
  assign take       = enable & in_valid & in_ready;
  assign flush_take = enable & flush & slot_free;

  bgt_accum #(
    .TS_W(TS_W), .LEN_W(LEN_W), .GAP_W(GAP_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W)
  ) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .take      (take),
    .cur_ts    (in_ts),
    .cur_len   (in_len),
    .gap_max   (gap_max),
    .flush_take(flush_take),
    .emit      (emit),
    .emit_pkts (emit_pkts),
    .emit_bytes(emit_bytes)
  );

  bgt_out_slot #(.PKT_W(PKT_W), .BYTE_W(BYTE_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (emit),
    .load_pkts (emit_pkts),
    .load_bytes(emit_bytes),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_pkts  (out_pkts),
    .out_bytes (out_bytes),
    .free      (slot_free)
  );

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && out_valid && !out_ready) |-> !in_ready);
  assert_flush_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && flush) |-> !take);
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !emit);
endmodule

// File: tb/burst_gap_tracker_tb.sv
module burst_gap_tracker_tb;
  localparam int TS_W = 64, LEN_W = 14, GAP_W = 16, PKT_W = 5, BYTE_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b1;
  logic flush = 1'b0;
  logic [GAP_W-1:0] gap_max = 16'd12;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [TS_W-1:0] in_ts = '0;
  logic [LEN_W-1:0] in_len = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [PKT_W-1:0] out_pkts;
  logic [BYTE_W-1:0] out_bytes;

  int n_chk = 0;
  int n_bad = 0;
  int n_rec = 0;
  int rec_p [0:63];
  int rec_b [0:63];
  int cyc = 0;

  always #2 clk = ~clk;

  burst_gap_tracker #(
    .TS_W(TS_W), .LEN_W(LEN_W), .GAP_W(GAP_W), .PKT_W(PKT_W), .BYTE_W(BYTE_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .flush(flush), .gap_max(gap_max),
    .in_valid(in_valid), .in_ready(in_ready), .in_ts(in_ts), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_pkts(out_pkts), .out_bytes(out_bytes)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && n_rec < 64) begin
      rec_p[n_rec] = int'(out_pkts);
      rec_b[n_rec] = int'(out_bytes);
      n_rec = n_rec + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] ts, input int len);
    in_valid = 1'b1;
    in_ts    = ts;
    in_len   = LEN_W'(len);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    while (!(!out_valid || out_ready)) @(negedge clk);
    @(negedge clk);
    flush = 1'b0;
    settle();
  endtask

  task automatic expect_rec(input int base, input int k, input int p, input int b, input string req);
    check(n_rec > base + k, req, "record present", n_rec - base, k + 1);
    if (n_rec > base + k) begin
      check(rec_p[base+k] == p, req, "frame count", rec_p[base+k], p);
      check(rec_b[base+k] == b, req, "byte count", rec_b[base+k], b);
    end
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_threshold();
    int base = n_rec;
    gap_max = 16'd12;
    send(64'd1000, 100);
    settle();
    check(n_rec == base, "R3", "first frame emits nothing", n_rec - base, 0);
    send(64'd1120, 60);
    send(64'd1200, 40);
    settle();
    check(n_rec == base, "R1", "gap equal to limit extends", n_rec - base, 0);
    send(64'd1261, 50);
    settle();
    expect_rec(base, 0, 3, 200, "R1");
    do_flush();
    expect_rec(base, 1, 1, 50, "R2");
    do_flush();
    check(n_rec == base + 2, "R6", "flush with nothing open", n_rec - base, 2);
  endtask

  task automatic t_negative();
    int base = n_rec;
    gap_max = 16'd12;
    send(64'd5000, 100);
    send(64'd5050, 10);
    do_flush();
    check(n_rec == base + 1, "R4", "single record for clamped gap", n_rec - base, 1);
    expect_rec(base, 0, 2, 110, "R4");
  endtask

  task automatic t_limit_sat();
    int base = n_rec;
    gap_max = 16'hFFFF;
    send(64'd100000, 1);
    send(64'd165536, 1);
    send(64'd231073, 1);
    settle();
    expect_rec(base, 0, 2, 2, "R5");
    do_flush();
    expect_rec(base, 1, 1, 1, "R5");
  endtask

  task automatic t_wrap();
    int base = n_rec;
    gap_max = 16'd40;
    send(64'hFFFF_FFFF_FFFF_FFCE, 20);
    send(64'd10, 20);
    send(64'd79, 5);
    settle();
    expect_rec(base, 0, 2, 40, "R11");
    do_flush();
    expect_rec(base, 1, 1, 5, "R11");
  endtask

  task automatic t_saturate();
    int base = n_rec;
    longint t = 300000;
    gap_max = 16'd12;
    for (int i = 0; i < 5; i++) begin
      send(64'(t), 16383);
      t = t + 16383;
    end
    do_flush();
    expect_rec(base, 0, 5, 65535, "R7");
    t = 500000;
    for (int i = 0; i < 33; i++) begin
      send(64'(t), 1);
      t = t + 1;
    end
    do_flush();
    expect_rec(base, 1, 31, 33, "R7");
  endtask

  task automatic t_backpressure();
    int base = n_rec;
    gap_max = 16'd12;
    out_ready = 1'b0;
    send(64'd700000, 100);
    send(64'd800000, 100);
    check(out_valid == 1'b1, "R8", "record waiting", out_valid, 1);
    check(in_ready == 1'b0, "R8", "input stalled", in_ready, 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R8", "valid held", out_valid, 1);
    check(out_pkts == 5'd1 && out_bytes == 16'd100, "R8", "data held (bytes)", out_bytes, 100);
    flush = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R6", "in_ready low during flush", in_ready, 0);
    flush = 1'b0;
    out_ready = 1'b1;
    settle();
    expect_rec(base, 0, 1, 100, "R8");
    do_flush();
    expect_rec(base, 1, 1, 100, "R6");
  endtask

  task automatic t_enable();
    int base = n_rec;
    gap_max = 16'd12;
    send(64'd900000, 10);
    send(64'd900010, 10);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R9", "in_ready while disabled", in_ready, 1);
    send(64'd900020, 10);
    settle();
    check(n_rec == base, "R9", "dropped burst emits nothing", n_rec - base, 0);
    enable = 1'b1;
    send(64'd950000, 7);
    settle();
    check(n_rec == base, "R3", "first frame after enable silent", n_rec - base, 0);
    do_flush();
    check(n_rec == base + 1, "R9", "one record after re-enable", n_rec - base, 1);
    expect_rec(base, 0, 1, 7, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_negative();
    t_limit_sat();
    t_wrap();
    t_saturate();
    t_backpressure();
    t_enable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule